// File: doc/BRIEF.md
# Phase-Alignable Clock Divider Bank

The block takes one source clock, passes it through a single shared gate and feeds the gated clock to a row of identical integer dividers. Each divider has its own ratio from 1 to 8 and its own clock enable. A ratio of 1 forwards the gated clock unchanged.

Because each divider counts independently, outputs that should share a phase can drift apart. Examples are a reset released between two source edges, or a ratio changed while running. A sequencer on a separate free-running control clock fixes this when `align_req_i` rises. It stops the shared clock, clears every divider, releases the clears and then restarts the clock. The first source edge after the restart makes every divider rise together. `aligned_o` reports that this restart has taken place.

The gate has two build-time variants. In the retimed variant, the enable passes through a synchroniser and a falling-edge stage in the source domain, so the gated clock can never be cut short. In the direct variant, the enable is combined with the source clock as it arrives.

Top module: `rdiv_bank`

## Requirements
- R1: Each divider takes a 3-bit ratio field in `ratio_i`; field k sits at bits [3k+2:3k], and field value v selects divide-by-(v+1). Rising edges of a divider output are v+1 source cycles apart. Value 0 forwards the gated source clock.
- R2: For a ratio N of 2 or more, the output stays high for floor(N/2) source cycles of each period.
- R3: A rising edge of `align_req_i`, seen on a control edge while the sequencer is idle, starts an alignment and drops `aligned_o` on that same edge. The sequence has three steps: gate off, clear, release. Each step lasts HOLD control cycles (HOLD at least 2). `aligned_o` rises, and the gate is re-enabled, exactly 3*HOLD control edges after the accepting edge.
- R4: While the sequence runs, no divider output makes a rising edge.
- R5: After an alignment, every divider of the bank makes its first rising edge on the same source edge. Dividers with equal ratios therefore keep rising together.
- R6: Further rising edges of `align_req_i` while a sequence is running are ignored. They do not change the time at which `aligned_o` rises.
- R7: While its `ce_i` bit is low, a divider with ratio 2 or more holds its state and makes no rising edge. Its first rising edge comes on the first source edge that samples `ce_i` high.
- R8: During reset `aligned_o` and all divider outputs are low. After reset the gate is enabled and `aligned_o` stays low until the first completed alignment.
- R9: With SYNC_GATE=1 the re-enable is retimed into the source domain. The first divider edge after an alignment comes SYNC_STAGES source cycles later than with SYNC_GATE=0, where the enable is applied directly.
- R10: Once high, `aligned_o` stays high until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Shared source clock feeding the gate |
| ctrl_clk_i | input | 1 | Free-running clock of the alignment sequencer |
| rst_ni | input | 1 | Asynchronous reset, active low |
| align_req_i | input | 1 | Alignment request, rising edge in the control domain |
| ratio_i | input | N_DIV*3 | Per-divider ratio fields, value v means divide by v+1 |
| ce_i | input | N_DIV | Per-divider clock enable, synchronous to the source clock |
| div_clk_o | output | N_DIV | Divided clock outputs |
| aligned_o | output | 1 | High once the gate has been reopened after an alignment |

## Verification
Two instances are driven with the same stimulus, one with the retimed gate and one with the direct gate. Ratio patterns are all-maximum, all-pass-through, a mixed ladder and seeded random sets in which two dividers always share a ratio. Together they separate a wrong period from a wrong high time, and a divider that restarts on a different edge from a correct but shifted one. A second request is pulsed in the middle of every sequence, which exposes a sequencer that restarts. One round holds a divider's enable low across the alignment and then raises it at a known edge. This tells a held count apart from a free-running one.

// File: rtl/rdiv_pkg.sv
`timescale 1ns/1ps
package rdiv_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_GATE = 2'd1,
    SEQ_CLR  = 2'd2,
    SEQ_REL  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rdiv_seq.sv
`timescale 1ns/1ps
module rdiv_seq import rdiv_pkg::*; #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic gate_en_o,
  output logic clr_o,
  output logic aligned_o
);
  localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          req_q;
  logic          step_done;

  assign step_done = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_RUN;
      cnt_q     <= '0;
      req_q     <= 1'b0;
      gate_en_o <= 1'b1;
      clr_o     <= 1'b0;
      aligned_o <= 1'b0;
    end else begin
      req_q <= req_i;
      unique case (state_q)
        SEQ_RUN: begin
          if (req_i && !req_q) begin
            state_q   <= SEQ_GATE;
            cnt_q     <= '0;
            gate_en_o <= 1'b0;
            aligned_o <= 1'b0;
          end
        end
        SEQ_GATE: begin
          if (step_done) begin
            state_q <= SEQ_CLR;
            cnt_q   <= '0;
            clr_o   <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SEQ_CLR: begin
          if (step_done) begin
            state_q <= SEQ_REL;
            cnt_q   <= '0;
            clr_o   <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SEQ_REL: begin
          if (step_done) begin
            state_q   <= SEQ_RUN;
            cnt_q     <= '0;
            gate_en_o <= 1'b1;
            aligned_o <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rdiv_gate.sv
`timescale 1ns/1ps
module rdiv_gate #(
  parameter bit SYNC_GATE   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  generate
    if (SYNC_GATE) begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   en_lo_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
      end

      // enable changes only while the source is low: no cut pulses
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_lo_q <= 1'b1;
        else         en_lo_q <= sync_q[SYNC_STAGES-1];
      end

      assign gclk_o = clk_i & en_lo_q;
    end else begin : g_direct
      assign gclk_o = clk_i & en_i;
    end
  endgenerate
endmodule

// File: rtl/rdiv_div.sv
`timescale 1ns/1ps
module rdiv_div #(
  parameter int MAX_RATIO = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         ce_i,
  input  logic [$clog2(MAX_RATIO)-1:0] ratio_i,
  output logic                         clk_o
);
  localparam int RW = $clog2(MAX_RATIO);
  localparam logic [RW-1:0] CNT_TOP = RW'(MAX_RATIO - 1);

  logic          arst_n;
  logic [RW-1:0] cnt_q, cnt_nxt;
  logic [RW:0]   half;
  logic          out_q;
  logic          ce_lat;

  assign arst_n = rst_ni & ~clr_i;
  // high phase length floor(N/2), N = ratio_i + 1
  assign half   = ({1'b0, ratio_i} + 1'b1) >> 1;

  // clear parks the count at the top so the first edge wraps to zero
  always_comb begin
    cnt_nxt = (cnt_q >= ratio_i) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= CNT_TOP;
      out_q <= 1'b0;
    end else if (ce_i) begin
      cnt_q <= cnt_nxt;
      out_q <= ({1'b0, cnt_nxt} < half);
    end
  end

  // enable for the pass-through path, transparent while the clock is low
  always_latch begin
    if (!clk_i) ce_lat <= ce_i;
  end

  assign clk_o = (ratio_i == '0) ? (clk_i & ce_lat & arst_n) : out_q;
endmodule

// File: rtl/rdiv_bank.sv
`timescale 1ns/1ps
module rdiv_bank #(
  parameter int N_DIV       = 4,
  parameter int MAX_RATIO   = 8,
  parameter int HOLD        = 4,
  parameter bit SYNC_GATE   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 src_clk_i,
  input  logic                                 ctrl_clk_i,
  input  logic                                 rst_ni,
  input  logic                                 align_req_i,
  input  logic [N_DIV*$clog2(MAX_RATIO)-1:0]   ratio_i,
  input  logic [N_DIV-1:0]                     ce_i,
  output logic [N_DIV-1:0]                     div_clk_o,
  output logic                                 aligned_o
);
  localparam int RW = $clog2(MAX_RATIO);

  logic gate_en;
  logic div_clr;
  logic gclk;

  rdiv_seq #(.HOLD(HOLD)) u_seq (
    .clk_i     (ctrl_clk_i),
    .rst_ni    (rst_ni),
    .req_i     (align_req_i),
    .gate_en_o (gate_en),
    .clr_o     (div_clr),
    .aligned_o (aligned_o)
  );

  rdiv_gate #(.SYNC_GATE(SYNC_GATE), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk_i  (src_clk_i),
    .rst_ni (rst_ni),
    .en_i   (gate_en),
    .gclk_o (gclk)
  );

  generate
    for (genvar k = 0; k < N_DIV; k++) begin : g_div
      rdiv_div #(.MAX_RATIO(MAX_RATIO)) u_div (
        .clk_i   (gclk),
        .rst_ni  (rst_ni),
        .clr_i   (div_clr),
        .ce_i    (ce_i[k]),
        .ratio_i (ratio_i[k*RW +: RW]),
        .clk_o   (div_clk_o[k])
      );
    end
  endgenerate
endmodule

// File: rtl/rdiv_bank_chk.sv
`timescale 1ns/1ps
module rdiv_bank_chk (
  input logic ctrl_clk_i,
  input logic rst_ni,
  input logic align_req_i,
  input logic gate_en,
  input logic div_clr,
  input logic aligned_o
);
  // R3
  clr_gated_chk: assert property (@(posedge ctrl_clk_i) disable iff (!rst_ni)
    div_clr |-> !gate_en);

  // R3
  release_gated_chk: assert property (@(posedge ctrl_clk_i) disable iff (!rst_ni)
    $fell(div_clr) |-> !gate_en);

  // R3
  rise_after_release_chk: assert property (@(posedge ctrl_clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> $past(!div_clr && !gate_en));

  // R10
  aligned_open_chk: assert property (@(posedge ctrl_clk_i) disable iff (!rst_ni)
    aligned_o |-> gate_en);

  // R10
  drop_on_req_chk: assert property (@(posedge ctrl_clk_i) disable iff (!rst_ni)
    $fell(aligned_o) |-> $past(align_req_i));
endmodule

bind rdiv_bank rdiv_bank_chk u_chk (
  .ctrl_clk_i  (ctrl_clk_i),
  .rst_ni      (rst_ni),
  .align_req_i (align_req_i),
  .gate_en     (gate_en),
  .div_clr     (div_clr),
  .aligned_o   (aligned_o)
);

// File: tb/rdiv_bank_tb.sv
`timescale 1ns/1ps
module rdiv_bank_tb;
  localparam int N    = 4;
  localparam int RW   = 3;
  localparam int HOLD = 4;
  localparam int STG  = 2;
  localparam int NC   = 2 * N;

  logic src_clk = 1'b0;
  logic ctrl_clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [N*RW-1:0] ratio = '0;
  logic [N-1:0] ce = '1;
  logic [N-1:0] div_s, div_a;
  logic al_s, al_a;
  logic [NC-1:0] ch;

  int checks = 0, errors = 0, tick = 0;
  bit done = 1'b0;
  logic [NC-1:0] prev = '0;
  int nrise[NC], t_first[NC], t_second[NC], t_fall[NC];
  bit fell[NC];

  always #2.5 src_clk = ~src_clk;
  // control edges fall in the low phase of the source clock
  initial begin
    #6;
    forever begin ctrl_clk = 1'b1; #20; ctrl_clk = 1'b0; #20; end
  end

  rdiv_bank #(.N_DIV(N), .MAX_RATIO(8), .HOLD(HOLD), .SYNC_GATE(1'b1), .SYNC_STAGES(STG)) u_dut (
    .src_clk_i(src_clk), .ctrl_clk_i(ctrl_clk), .rst_ni(rst_n), .align_req_i(req),
    .ratio_i(ratio), .ce_i(ce), .div_clk_o(div_s), .aligned_o(al_s));

  rdiv_bank #(.N_DIV(N), .MAX_RATIO(8), .HOLD(HOLD), .SYNC_GATE(1'b0), .SYNC_STAGES(STG)) u_dut_async (
    .src_clk_i(src_clk), .ctrl_clk_i(ctrl_clk), .rst_ni(rst_n), .align_req_i(req),
    .ratio_i(ratio), .ce_i(ce), .div_clk_o(div_a), .aligned_o(al_a));

  assign ch = {div_a, div_s};

  always @(negedge src_clk) begin
    #1;
    prev = ch;
  end

  always @(posedge src_clk) begin
    #1;
    tick++;
    for (int c = 0; c < NC; c++) begin
      if (ch[c] && !prev[c]) begin
        if (nrise[c] == 0) t_first[c] = tick;
        else if (nrise[c] == 1) t_second[c] = tick;
        nrise[c]++;
      end
      if (!ch[c] && prev[c] && nrise[c] == 1 && !fell[c]) begin
        fell[c] = 1'b1;
        t_fall[c] = tick;
      end
    end
    prev = ch;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic int div_of(input int c);
    return int'(ratio[(c % N)*RW +: RW]) + 1;
  endfunction

  task automatic clear_track();
    for (int c = 0; c < NC; c++) begin nrise[c] = 0; fell[c] = 1'b0; end
  endtask

  task automatic set_ratio(input int k, input int v);
    ratio[k*RW +: RW] = RW'(v);
  endtask

  task automatic align_round(input bit ce_test);
    int e, cap;
    @(negedge ctrl_clk); req = 1'b1;
    @(posedge ctrl_clk); #1;
    chk(!al_s && !al_a, "R3 drop", int'(al_s), 0);
    @(negedge ctrl_clk); req = 1'b0;
    @(posedge ctrl_clk);
    @(negedge ctrl_clk);
    clear_track();
    req = 1'b1;                      // R6: pulse during the sequence
    @(negedge ctrl_clk); req = 1'b0;
    e = 2;
    while (!al_s && e < 60) begin @(posedge ctrl_clk); #1; e++; end
    chk(e == 3*HOLD, "R3/R6 aligned timing", e, 3*HOLD);
    chk(al_a == al_s, "R3 async aligned", int'(al_a), int'(al_s));
    for (int c = 0; c < NC; c++) chk(nrise[c] == 0, "R4 gated", nrise[c], 0);
    clear_track();
    repeat (40) @(posedge src_clk);
    #2;
    for (int c = 0; c < NC; c++) begin
      int base = (c < N) ? 0 : N;
      int nd = div_of(c);
      if (ce_test && (c % N) == 2) begin
        chk(nrise[c] == 0, "R7 held", nrise[c], 0);
      end else begin
        chk(t_first[c] == t_first[base], "R5 first edge", t_first[c], t_first[base]);
        chk(t_second[c] - t_first[c] == nd, "R1 period", t_second[c] - t_first[c], nd);
        if (nd > 1) chk(t_fall[c] - t_first[c] == nd / 2, "R2 high time", t_fall[c] - t_first[c], nd / 2);
      end
    end
    chk(t_first[0] - t_first[N] == STG, "R9 retime delay", t_first[0] - t_first[N], STG);
    chk(al_s && al_a, "R10 held", int'(al_s & al_a), 1);
    if (ce_test) begin
      @(posedge src_clk); #2;
      nrise[2] = 0; nrise[N+2] = 0;
      ce[2] = 1'b1;
      cap = tick;
      repeat (20) @(posedge src_clk);
      #2;
      chk(t_first[2] == cap + 1, "R7 first edge", t_first[2], cap + 1);
      chk(t_first[N+2] == cap + 1, "R7 first edge async", t_first[N+2], cap + 1);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000C10C));
    for (int k = 0; k < N; k++) set_ratio(k, k);
    clear_track();
    repeat (6) @(posedge src_clk);
    #1;
    // R8: reset state
    chk(!al_s && !al_a, "R8 aligned in reset", int'(al_s | al_a), 0);
    chk(ch == '0, "R8 outputs in reset", int'(ch), 0);
    @(negedge src_clk); rst_n = 1'b1;
    repeat (20) @(posedge src_clk);
    #1;
    chk(!al_s && !al_a, "R8 aligned after reset", int'(al_s | al_a), 0);

    for (int k = 0; k < N; k++) set_ratio(k, 7);   // all divide-by-8
    align_round(1'b0);
    for (int k = 0; k < N; k++) set_ratio(k, 0);   // all pass-through
    align_round(1'b0);
    set_ratio(0, 0); set_ratio(1, 1); set_ratio(2, 2); set_ratio(3, 3);
    align_round(1'b0);
    set_ratio(0, 1); set_ratio(1, 3); set_ratio(2, 4); set_ratio(3, 4);
    ce[2] = 1'b0;
    align_round(1'b1);
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < N; k++) set_ratio(k, int'($urandom_range(0, 7)));
      set_ratio(1, int'(ratio[0 +: RW]));
      align_round(1'b0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule